// File: doc/BRIEF.md
# Cascaded Timer Divisor Search Engine

This engine picks a pair of divide factors for two counters chained one after the other, so that the period of the second counter comes as close as it can to a requested period. The caller gives the requested period and the period of the base clock, both in nanoseconds, together with the pair already loaded in the counters and a rounding mode. A pulse on `start` begins a computation. When the result is ready, the block returns the two 16-bit load codes, the period the pair achieves and a one-cycle `done` pulse.

If the pair already loaded gives the request exactly, the engine returns it at once. Otherwise it divides the request by the base period to get a target product. It then walks the first factor upwards and, for each value of it, tries a few second factors near the target divided by the first. Along the way it keeps the closest result at or below the request and the closest at or above it. At the end the rounding mode chooses one of the two. Every division is done by a shared shift-and-subtract divider inside the block. The caller must supply a nonzero base period.

Top module: `cascade_div_search`

## Requirements
- R1: While reset is held and afterwards until the first result, `done` is 0 and `code_a`, `code_b` and `period_ns` are 0.
- R2: A current code of 0 counts as a factor of 65536. If both current factors lie in 2..65536 and their product times `base_ns` equals `req_ns`, the outputs return the current codes unchanged with `period_ns` = `req_ns`. In that case `done` is high in the cycle after the rising edge that follows the edge sampling `start`.
- R3: A current factor of 1 fails the exact-match shortcut even if the product matches, and the search runs instead.
- R4: The target T is `req_ns / base_ns`, truncated. The first factor f starts at max(T/65536, 2) and is tried while f ≤ T/f + 1 and f ≤ 65536. For each f, the second factor s starts at max(T/f, 2) and is tried while f·s ≤ T + f + 1 and s ≤ 65536.
- R5: Among tried pairs, the lower result is the largest f·s·base ≤ `req_ns` and the upper result is the smallest f·s·base ≥ `req_ns`. When two pairs give the same period, the pair tried first is kept.
- R6: `round_mode` 1 selects the lower result and `round_mode` 2 selects the upper result.
- R7: `round_mode` 0 and 3 select the upper result only if its distance from `req_ns` is strictly smaller than that of the lower result. On equal distance they select the lower result.
- R8: A chosen factor of 65536 is output as code 0, and any other factor is output as its own value.
- R9: `period_ns` equals f·s·`base_ns` for the chosen pair. If no tried pair falls on the selected side, the codes and the period are all 0.
- R10: `done` is high for exactly one cycle per accepted `start`.
- R11: A `start` that arrives while a computation is in progress is ignored. That computation finishes on the inputs sampled with its own `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a computation when idle |
| req_ns | input | 32 | Requested period in ns |
| base_ns | input | 16 | Base clock period in ns, nonzero |
| cur_a | input | 16 | Currently loaded first code (0 means 65536) |
| cur_b | input | 16 | Currently loaded second code (0 means 65536) |
| round_mode | input | 2 | 0/3 nearest, 1 down, 2 up |
| code_a | output | 16 | Chosen first code |
| code_b | output | 16 | Chosen second code |
| period_ns | output | 50 | Period achieved by the chosen pair |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Two conditions are the hardest to create from the ports. The first is a tie: the lower and upper results must sit at exactly the same distance from the request. The stimulus uses a prime target (103) with a 10 ns base, so the best products are 102 and 104, an equal 10 ns on either side. The second is a factor of 65536, which the stimulus reaches with a 1 ns base and a request of 131072. That case is run both through the search and through the exact-match shortcut, and each gives a different ordering of the code-0 factor. A further case uses a target of 2, where the lower side stays empty and the down mode must return the all-zero result.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [1:0] {
    RM_NEAR     = 2'd0,
    RM_DOWN     = 2'd1,
    RM_UP       = 2'd2,
    RM_NEAR_ALT = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FAST,
    ST_TDIV,
    ST_OUTER,
    ST_QWAIT,
    ST_INNER,
    ST_PICK
  } state_e;
endpackage

// File: rtl/cds_divider.sv
module cds_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem,
  output logic             done
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, num_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q  <= num;
        num_q  <= num;
        den_q  <= den;
        rem_q  <= '0;
        cnt_q  <= CW'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        quo_q <= {quo_q[NUM_W-2:0], fits};
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign done = done_q;

  // R4
  div_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && den_q != '0) |->
      ((NUM_W+DEN_W)'(quo_q) * (NUM_W+DEN_W)'(den_q) + (NUM_W+DEN_W)'(rem_q)
        == (NUM_W+DEN_W)'(num_q)) && (rem_q < den_q));
endmodule

// File: rtl/cds_bound_track.sv
module cds_bound_track #(
  parameter int PROD_W = 50,
  parameter int DIV_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [PROD_W-1:0] cand_ns,
  input  logic [DIV_W-1:0]  cand_a,
  input  logic [DIV_W-1:0]  cand_b,
  input  logic [PROD_W-1:0] req_ns,
  output logic [PROD_W-1:0] glb_ns,
  output logic [DIV_W-1:0]  glb_a,
  output logic [DIV_W-1:0]  glb_b,
  output logic [PROD_W-1:0] lub_ns,
  output logic [DIV_W-1:0]  lub_a,
  output logic [DIV_W-1:0]  lub_b,
  output logic              lub_vld
);
  logic take_lo, take_hi;

  assign take_lo = upd && (cand_ns <= req_ns) && (cand_ns > glb_ns);
  assign take_hi = upd && (cand_ns >= req_ns) && (!lub_vld || cand_ns < lub_ns);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      glb_ns  <= '0;
      glb_a   <= '0;
      glb_b   <= '0;
      lub_ns  <= '0;
      lub_a   <= '0;
      lub_b   <= '0;
      lub_vld <= 1'b0;
    end else begin
      if (take_lo) begin
        glb_ns <= cand_ns;
        glb_a  <= cand_a;
        glb_b  <= cand_b;
      end
      if (take_hi) begin
        lub_ns  <= cand_ns;
        lub_a   <= cand_a;
        lub_b   <= cand_b;
        lub_vld <= 1'b1;
      end
    end
  end

  // R5
  glb_below_chk: assert property (@(posedge clk) disable iff (rst)
    glb_ns <= req_ns);
  // R5
  lub_above_chk: assert property (@(posedge clk) disable iff (rst)
    lub_vld |-> lub_ns >= req_ns);
  // R5
  glb_rises_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> glb_ns >= $past(glb_ns));
endmodule

// File: rtl/cascade_div_search.sv
module cascade_div_search
  import cds_pkg::*;
#(
  parameter int REQ_W  = 32,
  parameter int BASE_W = 16,
  parameter int CODE_W = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [REQ_W-1:0]                   req_ns,
  input  logic [BASE_W-1:0]                  base_ns,
  input  logic [CODE_W-1:0]                  cur_a,
  input  logic [CODE_W-1:0]                  cur_b,
  input  logic [1:0]                         round_mode,
  output logic [CODE_W-1:0]                  code_a,
  output logic [CODE_W-1:0]                  code_b,
  output logic [2*(CODE_W+1)+BASE_W-1:0]     period_ns,
  output logic                               done
);
  localparam int DIV_W  = CODE_W + 1;
  localparam int PROD_W = 2 * DIV_W + BASE_W;
  localparam int CMP_W  = REQ_W + 1;
  localparam logic [DIV_W-1:0] MAXDIV = {1'b1, {CODE_W{1'b0}}};
  localparam logic [DIV_W-1:0] TWO    = DIV_W'(2);

  state_e              state_q;
  logic [REQ_W-1:0]    req_q, tgt_q;
  logic [BASE_W-1:0]   base_q;
  logic [DIV_W-1:0]    cura_q, curb_q, d1_q, d2_q;
  rmode_e              mode_q;
  logic [CODE_W-1:0]   code_a_q, code_b_q;
  logic [PROD_W-1:0]   period_q;
  logic                done_q;

  // shared divider
  logic                div_start, div_done;
  logic [REQ_W-1:0]    div_num, div_quo;
  logic [DIV_W-1:0]    div_den, div_rem;

  assign div_start = (state_q == ST_FAST && !fast_ok) ||
                     (state_q == ST_OUTER && d1_q <= MAXDIV);
  assign div_num   = (state_q == ST_FAST) ? req_q : tgt_q;
  assign div_den   = (state_q == ST_FAST) ? DIV_W'(base_q) : d1_q;

  cds_divider #(.NUM_W(REQ_W), .DEN_W(DIV_W)) divider_i (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .quo(div_quo), .rem(div_rem), .done(div_done)
  );

  // exact-match shortcut
  logic [PROD_W-1:0] fast_prod;
  logic              fast_ok;
  assign fast_prod = PROD_W'(cura_q) * PROD_W'(curb_q) * PROD_W'(base_q);
  assign fast_ok   = (cura_q >= TWO) && (curb_q >= TWO) &&
                     (fast_prod == PROD_W'(req_q));

  // candidate evaluation
  logic [PROD_W-1:0] pair_prod, inner_lim, cand_ns;
  logic              inner_ok;
  assign pair_prod = PROD_W'(d1_q) * PROD_W'(d2_q);
  assign inner_lim = PROD_W'(tgt_q) + PROD_W'(d1_q) + PROD_W'(1);
  assign inner_ok  = (pair_prod <= inner_lim) && (d2_q <= MAXDIV);
  assign cand_ns   = pair_prod * PROD_W'(base_q);

  logic [PROD_W-1:0] glb_ns, lub_ns;
  logic [DIV_W-1:0]  glb_a, glb_b, lub_a, lub_b;
  logic              lub_vld;

  cds_bound_track #(.PROD_W(PROD_W), .DIV_W(DIV_W)) track_i (
    .clk(clk), .rst(rst),
    .clr(state_q == ST_IDLE && start),
    .upd(state_q == ST_INNER && inner_ok),
    .cand_ns(cand_ns), .cand_a(d1_q), .cand_b(d2_q),
    .req_ns(PROD_W'(req_q)),
    .glb_ns(glb_ns), .glb_a(glb_a), .glb_b(glb_b),
    .lub_ns(lub_ns), .lub_a(lub_a), .lub_b(lub_b), .lub_vld(lub_vld)
  );

  // rounding choice
  logic [PROD_W-1:0] err_up, err_dn;
  logic              take_up;
  assign err_up = lub_ns - PROD_W'(req_q);
  assign err_dn = PROD_W'(req_q) - glb_ns;
  always_comb begin
    case (mode_q)
      RM_UP:   take_up = 1'b1;
      RM_DOWN: take_up = 1'b0;
      default: take_up = lub_vld && (err_up < err_dn);
    endcase
  end

  // divider result helpers
  logic [REQ_W-1:0] first_lo;
  logic [DIV_W-1:0] q_sat;
  assign first_lo = div_quo >> CODE_W;
  assign q_sat    = (|(div_quo >> DIV_W)) ? '1 : DIV_W'(div_quo);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      req_q    <= '0;
      tgt_q    <= '0;
      base_q   <= '0;
      cura_q   <= '0;
      curb_q   <= '0;
      d1_q     <= '0;
      d2_q     <= '0;
      mode_q   <= RM_NEAR;
      code_a_q <= '0;
      code_b_q <= '0;
      period_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          req_q   <= req_ns;
          base_q  <= base_ns;
          cura_q  <= (cur_a == '0) ? MAXDIV : DIV_W'(cur_a);
          curb_q  <= (cur_b == '0) ? MAXDIV : DIV_W'(cur_b);
          mode_q  <= rmode_e'(round_mode);
          state_q <= ST_FAST;
        end
        ST_FAST: if (fast_ok) begin
          code_a_q <= cura_q[CODE_W-1:0];
          code_b_q <= curb_q[CODE_W-1:0];
          period_q <= PROD_W'(req_q);
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end else begin
          state_q <= ST_TDIV;
        end
        ST_TDIV: if (div_done) begin
          tgt_q   <= div_quo;
          d1_q    <= (first_lo < REQ_W'(2)) ? TWO : DIV_W'(first_lo);
          state_q <= ST_OUTER;
        end
        ST_OUTER: state_q <= (d1_q > MAXDIV) ? ST_PICK : ST_QWAIT;
        ST_QWAIT: if (div_done) begin
          if (CMP_W'(d1_q) > CMP_W'(div_quo) + CMP_W'(1)) begin
            state_q <= ST_PICK;
          end else begin
            d2_q    <= (q_sat < TWO) ? TWO : q_sat;
            state_q <= ST_INNER;
          end
        end
        ST_INNER: if (inner_ok) begin
          d2_q <= d2_q + DIV_W'(1);
        end else begin
          d1_q    <= d1_q + DIV_W'(1);
          state_q <= ST_OUTER;
        end
        ST_PICK: begin
          code_a_q <= take_up ? lub_a[CODE_W-1:0] : glb_a[CODE_W-1:0];
          code_b_q <= take_up ? lub_b[CODE_W-1:0] : glb_b[CODE_W-1:0];
          period_q <= take_up ? (lub_vld ? lub_ns : '0) : glb_ns;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_a    = code_a_q;
  assign code_b    = code_b_q;
  assign period_ns = period_q;
  assign done      = done_q;

  function automatic logic [PROD_W-1:0] code_val(input logic [CODE_W-1:0] c);
    return (c == '0) ? PROD_W'(MAXDIV) : PROD_W'(c);
  endfunction

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  period_match_chk: assert property (@(posedge clk) disable iff (rst)
    (done && period_ns != '0) |->
      period_ns == code_val(code_a) * code_val(code_b) * PROD_W'(base_q));
  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && period_ns != '0) |->
      (code_val(code_a) >= PROD_W'(2)) && (code_val(code_b) >= PROD_W'(2)));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start) |=> $stable(req_q));
endmodule

// File: tb/cascade_div_search_tb_top.sv
module cascade_div_search_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] req_ns;
  logic [15:0] base_ns, cur_a, cur_b;
  logic [1:0]  round_mode;
  logic [15:0] code_a, code_b;
  logic [49:0] period_ns;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cascade_div_search dut_i (
    .clk(clk), .rst(rst), .start(start), .req_ns(req_ns), .base_ns(base_ns),
    .cur_a(cur_a), .cur_b(cur_b), .round_mode(round_mode),
    .code_a(code_a), .code_b(code_b), .period_ns(period_ns), .done(done)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [15:0] base;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [1:0]  mode;
    logic [15:0] ea;
    logic [15:0] eb;
    logic [49:0] ep;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'd1000,   16'd10, 16'd0, 16'd0,   2'd0, 16'd2, 16'd50, 50'd1000,   8'd5},  // R5 earliest exact pair
    '{32'd1030,   16'd10, 16'd0, 16'd0,   2'd0, 16'd2, 16'd51, 50'd1020,   8'd7},  // R7 tie -> lower
    '{32'd1030,   16'd10, 16'd0, 16'd0,   2'd1, 16'd2, 16'd51, 50'd1020,   8'd6},  // R6 down
    '{32'd1030,   16'd10, 16'd0, 16'd0,   2'd2, 16'd2, 16'd52, 50'd1040,   8'd6},  // R6 up
    '{32'd1030,   16'd10, 16'd0, 16'd0,   2'd3, 16'd2, 16'd51, 50'd1020,   8'd7},  // R7 code 3
    '{32'd1035,   16'd10, 16'd0, 16'd0,   2'd0, 16'd2, 16'd52, 50'd1040,   8'd7},  // R7 upper closer
    '{32'd1000,   16'd10, 16'd4, 16'd25,  2'd0, 16'd4, 16'd25, 50'd1000,   8'd2},  // R2 shortcut
    '{32'd1000,   16'd10, 16'd1, 16'd100, 2'd0, 16'd2, 16'd50, 50'd1000,   8'd3},  // R3 factor 1
    '{32'd131072, 16'd1,  16'd0, 16'd0,   2'd1, 16'd2, 16'd0,  50'd131072, 8'd8},  // R8 65536 -> 0
    '{32'd131072, 16'd1,  16'd0, 16'd2,   2'd2, 16'd0, 16'd2,  50'd131072, 8'd2},  // R2 code 0 shortcut
    '{32'd25,     16'd10, 16'd0, 16'd0,   2'd0, 16'd2, 16'd2,  50'd40,     8'd4},  // R4 second floor 2
    '{32'd25,     16'd10, 16'd0, 16'd0,   2'd1, 16'd0, 16'd0,  50'd0,      8'd9},  // R9 empty side
    '{32'd1009,   16'd10, 16'd0, 16'd0,   2'd2, 16'd2, 16'd51, 50'd1020,   8'd4},  // R4 truncated target
    '{32'd1009,   16'd10, 16'd0, 16'd0,   2'd0, 16'd2, 16'd50, 50'd1000,   8'd7}   // R7 lower closer
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] r, input logic [15:0] b,
                       input logic [15:0] a0, input logic [15:0] b0,
                       input logic [1:0] m);
    @(negedge clk);
    req_ns = r; base_ns = b; cur_a = a0; cur_b = b0; round_mode = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc, output bit seen);
    cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < 60000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    if (!seen) begin
      failures++;
      $display("FAIL watchdog: no done within %0d cycles", cyc);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    bit seen;
    rst = 1'b1; start = 1'b0; req_ns = '0; base_ns = 16'd1;
    cur_a = '0; cur_b = '0; round_mode = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && code_a == 0 && code_b == 0, "R1", "idle codes",
          {code_a, code_b}, 0);
    check(period_ns == 0, "R1", "idle period", period_ns, 0);

    for (int i = 0; i < NV; i++) begin
      string rs;
      rs = $sformatf("R%0d", VECS[i].rq);
      launch(VECS[i].req, VECS[i].base, VECS[i].ca, VECS[i].cb, VECS[i].mode);
      wait_done(cyc, seen);
      if (seen) begin
        check(code_a == VECS[i].ea, rs, $sformatf("vec %0d code_a", i), code_a, VECS[i].ea);
        check(code_b == VECS[i].eb, rs, $sformatf("vec %0d code_b", i), code_b, VECS[i].eb);
        check(period_ns == VECS[i].ep, rs, $sformatf("vec %0d period", i), period_ns, VECS[i].ep);
        if (VECS[i].rq == 8'd2)
          check(cyc == 1, "R2", "shortcut latency", cyc, 1);
        @(negedge clk);
        check(done == 1'b0, "R10", "done one cycle", done, 0);
      end
    end

    // R11: second start during a search is ignored
    launch(32'd1030, 16'd10, 16'd0, 16'd0, 2'd2);
    repeat (5) @(negedge clk);
    req_ns = 32'd1000; base_ns = 16'd10; cur_a = 16'd4; cur_b = 16'd25;
    round_mode = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc, seen);
    if (seen) begin
      check(code_a == 16'd2 && code_b == 16'd52, "R11", "busy start codes",
            {code_a, code_b}, {16'd2, 16'd52});
      check(period_ns == 50'd1040, "R11", "busy start period", period_ns, 1040);
      begin
        int extra = 0;
        for (int k = 0; k < 200; k++) begin
          @(negedge clk);
          if (done) extra++;
        end
        check(extra == 0, "R11", "no second done", extra, 0);
      end
    end

    // R10: a fresh start after idle yields exactly one pulse
    launch(32'd1000, 16'd10, 16'd4, 16'd25, 2'd0);
    begin
      int pulses = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (done) pulses++;
      end
      check(pulses == 1, "R10", "pulse count", pulses, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule